// File: doc/BRIEF.md
# 2D Strided Burst Address Generator

This block sits on one memory-mapped side of a DMA engine and turns a single transfer descriptor into a stream of burst requests. A descriptor gives a base address, a row length in bytes, a row count and a byte stride between row starts. The block walks the rows in order. It cuts each row into bursts that never exceed a configured maximum size. For every burst it presents a start address, a length in beats and a flag marking the final burst of the transfer.

Descriptors arrive on a valid/ready handshake, and bursts leave on a second valid/ready handshake toward the bus-request logic. A descriptor marked cyclic replays itself from the base address after its final burst, and keeps doing so until the channel is disabled. Clearing the enable input stops new bursts at the next burst boundary. A burst that is already presented stays presented until it is taken. The rest of the transfer is then dropped.

Top module: `burst_addr_gen_2d`

## Requirements
- R1: A row holds row-length field + 1 bytes, which must be a whole multiple of the bus width in bytes. A transfer holds row-count field + 1 rows.
- R2: Row N (counting from 0) begins at the aligned base address plus N times the aligned stride, with modulo 2^ADDR_W wrap.
- R3: Address bits below log2(BUS_BYTES) of both base and stride are forced to zero, so every presented burst address is bus aligned.
- R4: Within a row, each burst covers the smaller of MAX_BURST_BYTES and the bytes still left in that row. The next burst in the row starts MAX_BURST_BYTES higher.
- R5: `burst_beats` equals burst bytes divided by BUS_BYTES, minus 1.
- R6: With ENABLE_2D = 0 the row-count field is ignored and exactly one row is issued.
- R7: A descriptor accepted with `desc_cyclic` = 1 restarts at its base address, first row, after its last burst is taken, and repeats without end.
- R8: While `enable` is low no new burst is presented. A burst presented while `burst_ready` was low stays valid with unchanged address and length until taken. After that the transfer is abandoned and `burst_valid` stays low.
- R9: `burst_last` = 1 only on the last burst of the last row. `desc_ready` is low while a transfer is active. A non-cyclic transfer goes idle in the cycle after its last burst is taken.
- R10: After reset no burst is valid, and `desc_ready` equals `enable` while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Channel enable; low stops bursts at a boundary |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor accepted when both high |
| desc_base | input | ADDR_W | Transfer base address |
| desc_xlen | input | LEN_W | Bytes per row minus 1 |
| desc_ylen | input | LEN_W | Rows minus 1 |
| desc_stride | input | LEN_W | Bytes between row starts |
| desc_cyclic | input | 1 | Replay transfer after completion |
| burst_valid | output | 1 | Burst request presented |
| burst_ready | input | 1 | Burst request taken when both high |
| burst_addr | output | ADDR_W | Burst start address |
| burst_beats | output | log2(MAX_BURST_BYTES/BUS_BYTES) | Burst length in beats minus 1 |
| burst_last | output | 1 | Final burst of the transfer |

## Verification
A wrong row counter or remaining-beat count shows up at the very next accepted burst as a mis-stepped address or a wrong beat count. A wrong final-row compare shows up as a missing or early `burst_last`, and then as `desc_ready` rising at the wrong time. The scoreboard compares every taken burst against an independently computed list, so any such fault surfaces within one burst of its cause. The disable path is checked by stalling a presented burst, dropping enable, and observing the burst held stable. The transfer must then stop after that burst is taken.

// File: rtl/burst_addr_gen_2d.sv
module burst_addr_gen_2d #(
  parameter int ADDR_W          = 32,
  parameter int LEN_W           = 24,
  parameter int BUS_BYTES       = 8,
  parameter int MAX_BURST_BYTES = 128,
  parameter bit ENABLE_2D       = 1'b1
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          enable,
  input  logic                                          desc_valid,
  output logic                                          desc_ready,
  input  logic [ADDR_W-1:0]                             desc_base,
  input  logic [LEN_W-1:0]                              desc_xlen,
  input  logic [LEN_W-1:0]                              desc_ylen,
  input  logic [LEN_W-1:0]                              desc_stride,
  input  logic                                          desc_cyclic,
  output logic                                          burst_valid,
  input  logic                                          burst_ready,
  output logic [ADDR_W-1:0]                             burst_addr,
  output logic [$clog2(MAX_BURST_BYTES/BUS_BYTES)-1:0]  burst_beats,
  output logic                                          burst_last
);

  localparam int ALIGN_BITS = $clog2(BUS_BYTES);
  localparam int MAX_BEATS  = MAX_BURST_BYTES / BUS_BYTES;
  localparam int BEAT_W     = $clog2(MAX_BEATS);
  localparam int CNT_W      = LEN_W + 1;
  localparam logic [ADDR_W-1:0] ALIGN_MASK  = ADDR_W'(BUS_BYTES - 1);
  localparam logic [ADDR_W-1:0] MAX_STEP    = ADDR_W'(MAX_BURST_BYTES);
  localparam logic [CNT_W-1:0]  MAX_BEATS_C = CNT_W'(MAX_BEATS);

  logic              busy, held, cyc_q;
  logic [ADDR_W-1:0] base_q, stride_q, row_addr_q, cur_addr_q;
  logic [CNT_W-1:0]  row_beats_q, rem_q;
  logic [LEN_W-1:0]  rows_q, row_idx_q;

  logic [LEN_W-1:0]  rows_in;
  logic [CNT_W-1:0]  row_beats_in;
  logic [ADDR_W-1:0] base_in, stride_in;

  generate
    if (ENABLE_2D) begin : g_2d
      assign rows_in = desc_ylen;
    end else begin : g_1d
      assign rows_in = '0;
    end
  endgenerate

  assign row_beats_in = ({1'b0, desc_xlen} + 1'b1) >> ALIGN_BITS;
  assign base_in      = desc_base & ~ALIGN_MASK;
  assign stride_in    = ADDR_W'(desc_stride) & ~ALIGN_MASK;

  logic fits, last_row, take;
  logic [CNT_W-1:0] this_beats;

  assign desc_ready  = !busy && enable;
  assign burst_valid = busy && (enable || held);
  assign fits        = rem_q <= MAX_BEATS_C;
  assign this_beats  = fits ? rem_q : MAX_BEATS_C;
  assign burst_beats = BEAT_W'(this_beats - 1'b1);
  assign last_row    = row_idx_q == rows_q;
  assign burst_last  = last_row && fits;
  assign burst_addr  = cur_addr_q;
  assign take        = burst_valid && burst_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      held        <= 1'b0;
      cyc_q       <= 1'b0;
      base_q      <= '0;
      stride_q    <= '0;
      row_addr_q  <= '0;
      cur_addr_q  <= '0;
      row_beats_q <= '0;
      rem_q       <= '0;
      rows_q      <= '0;
      row_idx_q   <= '0;
    end else begin
      held <= burst_valid && !burst_ready;
      if (desc_valid && desc_ready) begin
        busy        <= 1'b1;
        cyc_q       <= desc_cyclic;
        base_q      <= base_in;
        stride_q    <= stride_in;
        row_beats_q <= row_beats_in;
        rows_q      <= rows_in;
        row_addr_q  <= base_in;
        cur_addr_q  <= base_in;
        rem_q       <= row_beats_in;
        row_idx_q   <= '0;
      end else if (take) begin
        if (!fits) begin
          cur_addr_q <= cur_addr_q + MAX_STEP;
          rem_q      <= rem_q - MAX_BEATS_C;
        end else if (!last_row) begin
          row_addr_q <= row_addr_q + stride_q;
          cur_addr_q <= row_addr_q + stride_q;
          rem_q      <= row_beats_q;
          row_idx_q  <= row_idx_q + 1'b1;
        end else if (cyc_q) begin
          row_addr_q <= base_q;
          cur_addr_q <= base_q;
          rem_q      <= row_beats_q;
          row_idx_q  <= '0;
        end else begin
          busy <= 1'b0;
        end
      end else if (busy && !burst_valid) begin
        busy <= 1'b0;
      end
    end
  end

  a_r3_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    burst_valid |-> (burst_addr & ALIGN_MASK) == '0);

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    burst_valid && !burst_ready |=> burst_valid && $stable(burst_addr) && $stable(burst_beats));

  a_r8_stop_after_disable: assert property (@(posedge clk) disable iff (!rst_n)
    !enable && !(burst_valid && !burst_ready) |=> !burst_valid);

  a_r9_no_desc_during_burst: assert property (@(posedge clk) disable iff (!rst_n)
    burst_valid |-> !desc_ready);

  a_r9_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    take && burst_last && !cyc_q |=> !burst_valid && (desc_ready == enable));

endmodule

// File: tb/burst_addr_gen_2d_tb.sv
module burst_addr_gen_2d_tb;
  localparam int AW = 32, LW = 24, BUSB = 8, MAXB = 128, BW = 4;
  localparam int MAXBEATS = MAXB / BUSB;
  localparam int EW = AW + BW + 1;

  logic clk = 0, rst_n = 0, enable = 0;
  logic dv0 = 0, dv1 = 0, cyc = 0, rdy_en = 1;
  logic [AW-1:0] base = '0;
  logic [LW-1:0] xlen = '0, ylen = '0, stride = '0;
  logic dr0, dr1, bv0, bv1, bl0, bl1, br0;
  logic [AW-1:0] ba0, ba1;
  logic [BW-1:0] bb0, bb1;
  logic [7:0] lfsr = 8'h5a;
  int vectors = 0, fails = 0;
  logic [EW-1:0] q0[$], q1[$];

  always #4 clk = ~clk;
  always @(posedge clk) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  assign br0 = rdy_en & (lfsr[0] | lfsr[3]);

  burst_addr_gen_2d #(.ADDR_W(AW), .LEN_W(LW), .BUS_BYTES(BUSB), .MAX_BURST_BYTES(MAXB), .ENABLE_2D(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .desc_valid(dv0), .desc_ready(dr0),
    .desc_base(base), .desc_xlen(xlen), .desc_ylen(ylen), .desc_stride(stride), .desc_cyclic(cyc),
    .burst_valid(bv0), .burst_ready(br0), .burst_addr(ba0), .burst_beats(bb0), .burst_last(bl0));

  burst_addr_gen_2d #(.ADDR_W(AW), .LEN_W(LW), .BUS_BYTES(BUSB), .MAX_BURST_BYTES(MAXB), .ENABLE_2D(1'b0)) u_dut_1d (
    .clk(clk), .rst_n(rst_n), .enable(enable), .desc_valid(dv1), .desc_ready(dr1),
    .desc_base(base), .desc_xlen(xlen), .desc_ylen(ylen), .desc_stride(stride), .desc_cyclic(cyc),
    .burst_valid(bv1), .burst_ready(1'b1), .burst_addr(ba1), .burst_beats(bb1), .burst_last(bl1));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && bv0 && br0) begin
      vectors++;
      if (q0.size() == 0) begin
        fails++;
        $display("FAIL R2 R4 R5 R9 got %h expected none", {ba0, bb0, bl0});
      end else begin
        logic [EW-1:0] e;
        e = q0.pop_front();
        if ({ba0, bb0, bl0} !== e) begin
          fails++;
          $display("FAIL R2 R4 R5 R9 got %h expected %h", {ba0, bb0, bl0}, e);
        end
      end
    end
    if (rst_n && bv1) begin
      vectors++;
      if (q1.size() == 0) begin
        fails++;
        $display("FAIL R6 got %h expected none", {ba1, bb1, bl1});
      end else begin
        logic [EW-1:0] e;
        e = q1.pop_front();
        if ({ba1, bb1, bl1} !== e) begin
          fails++;
          $display("FAIL R6 got %h expected %h", {ba1, bb1, bl1}, e);
        end
      end
    end
  end

  task automatic send(input bit one_d, input logic [AW-1:0] b, input int xl, input int yl,
                      input logic [AW-1:0] st, input bit c, input int reps);
    logic [AW-1:0] ab, ast, a;
    int rows, rb, rem, n;
    ab = b & ~AW'(BUSB - 1);
    ast = st & ~AW'(BUSB - 1);
    rows = one_d ? 1 : yl + 1;
    rb = (xl + 1) / BUSB;
    for (int k = 0; k < reps; k++)
      for (int r = 0; r < rows; r++) begin
        a = ab + AW'(r) * ast;
        rem = rb;
        while (rem > 0) begin
          n = (rem > MAXBEATS) ? MAXBEATS : rem;
          if (one_d) q1.push_back({a, BW'(n - 1), (r == rows - 1) && (rem == n)});
          else       q0.push_back({a, BW'(n - 1), (r == rows - 1) && (rem == n)});
          a = a + AW'(n * BUSB);
          rem = rem - n;
        end
      end
    @(negedge clk);
    while (!(one_d ? dr1 : dr0)) @(negedge clk);
    base = b; xlen = LW'(xl); ylen = LW'(yl); stride = LW'(st); cyc = c;
    if (one_d) dv1 = 1; else dv0 = 1;
    @(posedge clk);
    #1 dv0 = 0; dv1 = 0;
  endtask

  task automatic drain();
    wait (q0.size() == 0 && q1.size() == 0);
    repeat (3) @(negedge clk);
    chk(dr0 && !bv0 && dr1 && !bv1, "R9 idle after last", {dr0, bv0}, 2'b10);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(!bv0 && !dr0, "R10 reset idle, enable low", {bv0, dr0}, 2'b00);
    enable = 1;
    @(negedge clk);
    chk(dr0 && dr1, "R10 ready follows enable", {dr0, dr1}, 2'b11);

    // R1 R5: single short row
    send(0, 32'h1000, 63, 0, 32'h0, 0, 1);
    @(negedge clk);
    chk(!dr0, "R9 busy blocks descriptor", dr0, 0);
    drain();

    // R2 R3 R4: unaligned base/stride, three rows of 37 beats
    send(0, 32'h2003, 295, 2, 32'h405, 0, 1);
    @(negedge clk);
    chk(!dr0, "R9 busy blocks descriptor", dr0, 0);
    drain();

    // R4: row an exact multiple of the burst cap
    send(0, 32'h4000, 255, 0, 32'h0, 0, 1);
    drain();

    // R2: zero stride repeats row start
    send(0, 32'h5000, 135, 1, 32'h0, 0, 1);
    drain();

    // R6: row count ignored without 2D support
    send(1, 32'h3000, 127, 3, 32'h200, 0, 1);
    drain();
    send(1, 32'h3800, 255, 5, 32'h100, 0, 1);
    drain();

    // R7 R8: cyclic replay, then disable with a stalled burst
    send(0, 32'h8000, 191, 1, 32'h100, 1, 2);
    wait (q0.size() == 0);
    @(posedge clk);
    #1 rdy_en = 0;
    @(posedge clk);
    #1 enable = 0;
    repeat (4) @(negedge clk);
    chk(bv0 == 1'b1, "R8 stalled burst held after disable", bv0, 1);
    chk(ba0 == 32'h8000 && bb0 == 4'd15, "R7 cyclic restart at base", {ba0, bb0}, {32'h8000, 4'd15});
    q0.push_back({32'h8000, 4'd15, 1'b0});
    rdy_en = 1;
    wait (q0.size() == 0);
    repeat (3) @(negedge clk);
    chk(!bv0, "R8 no new burst while disabled", bv0, 0);
    chk(!dr0, "R8 R10 no descriptor while disabled", dr0, 0);
    enable = 1;
    @(negedge clk);
    chk(dr0, "R8 R10 ready after re-enable", dr0, 1);

    // R2 R9: fresh transfer after abandon
    send(0, 32'h9000, 31, 3, 32'h40, 0, 1);
    drain();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule